// File: doc/BRIEF.md
# Incremental Ones-Complement Checksum Accumulator

This unit keeps a running 16-bit Internet-style checksum for a packet pipeline. It accepts one command per accepted beat on a valid/ready command channel. A command can zero the accumulator, fold a data word into it, take a previously folded word back out, or request the current checksum. When a header field is rewritten, the pipeline removes the old field value and adds the new one. The checksum is then adjusted without summing the whole header again.

Checksum results leave on a separate valid/ready result channel that holds a single entry. A read result stays on `res_data` with `res_valid` high until the consumer takes it with `res_ready`. While a result waits and `res_ready` is low, `cmd_ready` is low, so no command of any kind is accepted. In every other state, `cmd_ready` is high and the unit takes one command per clock. A command is accepted on a rising edge where both `cmd_valid` and `cmd_ready` are high.

Top module: `csum16_accum`

## Requirements
- R1: After reset, `res_valid` is 0, `cmd_ready` is 1, and the accumulator is 0x0000, so a read issued first returns 0xFFFF.
- R2: An accepted clear command (code 2'd0) sets the accumulator to 0x0000.
- R3: An accepted add command (code 2'd1) replaces the accumulator with the ones-complement sum of the accumulator and `cmd_data`. The carry out of bit 15 is added back into bit 0 in the same cycle.
- R4: An accepted remove command (code 2'd2) adds the bitwise complement of `cmd_data` to the accumulator, with the same end-around carry.
- R5: An accepted read command (code 2'd3) raises `res_valid` on the next cycle, with `res_data` equal to the bitwise complement of the accumulator.
- R6: A read command leaves the accumulator unchanged.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_data` and `res_valid` hold, `cmd_ready` is 0, and commands presented on the input are ignored.
- R8: When `cmd_valid` is 0, the accumulator does not change, whatever is on `cmd_code` and `cmd_data`.
- R9: Adding all ten words of an IPv4 header that carries a correct checksum, after a clear, makes a read return 0x0000.
- R10: `res_valid` falls on the cycle after the result handshake, unless another read is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command beat present |
| cmd_ready | output | 1 | Unit can accept a command this cycle |
| cmd_code | input | 2 | 0 clear, 1 add, 2 remove, 3 read |
| cmd_data | input | 16 | Data word for add and remove |
| res_valid | output | 1 | Checksum result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 16 | Checksum (complement of accumulator) |

## Verification
The hardest state to reach is a stalled result with a command offered against it. A read is accepted while `res_ready` is low, and an add is then held on the input for two cycles while `cmd_ready` is low. After the stall is released, a second read shows whether the held add leaked into the accumulator. Carry wrap-around and the two zero encodings are reached with words chosen to overflow: 0x8000 twice, 0xF000, and 0xFFFF.

// File: rtl/csum_pkg.sv
package csum_pkg;
  typedef enum logic [1:0] {
    CMD_CLEAR = 2'd0,
    CMD_ADD   = 2'd1,
    CMD_SUB   = 2'd2,
    CMD_READ  = 2'd3
  } csum_cmd_e;
endpackage

// File: rtl/csum_oc_add.sv
// Ones-complement adder: binary sum, then the carry out is folded into bit 0.
module csum_oc_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int RW = W + 1;
  logic [RW-1:0] raw;

  assign raw = {1'b0, a} + {1'b0, b};
  // A second carry cannot occur: max low part after a carry is all-ones minus one.
  assign y = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
endmodule

// File: rtl/csum_core.sv
module csum_core
  import csum_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  csum_cmd_e     cmd,
  input  logic [W-1:0]  data,
  output logic [W-1:0]  acc
);
  logic [W-1:0] acc_r;
  logic [W-1:0] operand;
  logic [W-1:0] sum;

  // Removal reuses the adder by feeding the complemented word.
  assign operand = (cmd == CMD_SUB) ? ~data : data;

  csum_oc_add #(.W(W)) u_add (
    .a (acc_r),
    .b (operand),
    .y (sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_r <= '0;
    end else if (fire) begin
      case (cmd)
        CMD_CLEAR:        acc_r <= '0;
        CMD_ADD, CMD_SUB: acc_r <= sum;
        default:          acc_r <= acc_r;
      endcase
    end
  end

  assign acc = acc_r;
endmodule

// File: rtl/csum_resp.sv
// Single-entry result register with hold under back-pressure.
module csum_resp #(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  acc,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ~acc;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/csum16_accum.sv
module csum16_accum
  import csum_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_code,
  input  logic [W-1:0]  cmd_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [W-1:0]  res_data
);
  csum_cmd_e    cmd_e;
  logic         fire;
  logic         rd_fire;
  logic [W-1:0] acc_q;

  assign cmd_e     = csum_cmd_e'(cmd_code);
  assign cmd_ready = !res_valid || res_ready;
  assign fire      = cmd_valid && cmd_ready;
  assign rd_fire   = fire && (cmd_e == CMD_READ);

  csum_core #(.W(W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .cmd   (cmd_e),
    .data  (cmd_data),
    .acc   (acc_q)
  );

  csum_resp #(.W(W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_fire),
    .acc       (acc_q),
    .out_ready (res_ready),
    .out_valid (res_valid),
    .out_data  (res_data)
  );
endmodule

// File: rtl/csum16_accum_chk.sv
module csum16_accum_chk #(
  parameter int W = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_code,
  input logic          res_valid,
  input logic          res_ready,
  input logic [W-1:0]  res_data,
  input logic [W-1:0]  acc
);
  logic acc_fire;
  assign acc_fire = cmd_valid && cmd_ready;

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && cmd_code == 2'd0) |=> (acc == '0));

  // R5
  read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && cmd_code == 2'd3) |=> (res_valid && res_data == ~$past(acc)));

  // R6
  read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && cmd_code == 2'd3) |=> $stable(acc));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(acc)));

  // R8
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid) |=> $stable(acc));

  // R10
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !(cmd_valid && cmd_code == 2'd3)) |=> !res_valid);
endmodule

bind csum16_accum csum16_accum_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_code  (cmd_code),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .acc       (acc_q)
);

// File: tb/tb_csum16_accum.sv
module tb_csum16_accum;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  // codes: 0 clear, 1 add, 2 remove, 3 read
  localparam logic [1:0]  V_CMD  [NV] = '{2'd0, 2'd3, 2'd1, 2'd3, 2'd1, 2'd3, 2'd3, 2'd2,
                                          2'd3, 2'd1, 2'd3, 2'd0, 2'd1, 2'd1, 2'd3};
  localparam logic [15:0] V_DATA [NV] = '{16'h0, 16'h0, 16'h1234, 16'h0, 16'hF000, 16'h0, 16'h0,
                                          16'hF000, 16'h0, 16'hFFFF, 16'h0, 16'h0, 16'h8000,
                                          16'h8000, 16'h0};
  // R2 idx1, R3 idx3/5/10/14 (carry wrap), R6 idx6, R4 idx8
  localparam logic [15:0] V_EXP  [NV] = '{16'h0, 16'hFFFF, 16'h0, 16'hEDCB, 16'h0, 16'hFDCA,
                                          16'hFDCA, 16'h0, 16'hEDCB, 16'h0, 16'hEDCB, 16'h0,
                                          16'h0, 16'h0, 16'hFFFE};
  localparam logic [15:0] HDR [10] = '{16'h4500, 16'h0073, 16'h0000, 16'h4000, 16'h4011,
                                       16'hB861, 16'hC0A8, 16'h0001, 16'hC0A8, 16'h00C7};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_code = 2'd0;
  logic [15:0] cmd_data = 16'h0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [15:0] res_data;
  int          errors = 0;
  int          checks = 0;
  logic [15:0] held;

  always #(CLK_PERIOD/2) clk = ~clk;

  csum16_accum dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_data(cmd_data), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; presents one beat and returns at the next negedge.
  task automatic issue(input logic [1:0] c, input logic [15:0] d);
    cmd_valid = 1'b1;
    cmd_code  = c;
    cmd_data  = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
    issue(2'd3, 16'h0);
    chk("R1 first read", res_data, 16'hFFFF);

    for (int i = 0; i < NV; i++) begin
      issue(V_CMD[i], V_DATA[i]);
      if (V_CMD[i] == 2'd3) begin
        chk("R5 valid", res_valid, 1);
        chk("R5 vector data", res_data, V_EXP[i]);
      end
    end

    // R9: IPv4 header with correct checksum
    issue(2'd0, 16'h0);
    for (int k = 0; k < 10; k++) issue(2'd1, HDR[k]);
    issue(2'd3, 16'h0);
    chk("R9 header verify", res_data, 16'h0000);

    // R10: no read accepted while draining
    @(negedge clk);
    chk("R10 drain", res_valid, 0);

    // R8: idle with garbage on the bus
    issue(2'd0, 16'h0);
    issue(2'd1, 16'h0100);
    cmd_code = 2'd1;
    cmd_data = 16'h1111;
    repeat (3) @(negedge clk);
    issue(2'd3, 16'h0);
    chk("R8 idle ignored", res_data, 16'hFEFF);

    // R7: stall with a command offered
    @(negedge clk);
    res_ready = 1'b0;
    issue(2'd3, 16'h0);
    held = res_data;
    chk("R7 stalled valid", res_valid, 1);
    cmd_valid = 1'b1;
    cmd_code  = 2'd1;
    cmd_data  = 16'h0001;
    @(negedge clk);
    chk("R7 cmd_ready low", cmd_ready, 0);
    @(negedge clk);
    chk("R7 data held", res_data, held);
    chk("R7 valid held", res_valid, 1);
    cmd_valid = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    chk("R10 handshake drop", res_valid, 0);
    issue(2'd3, 16'h0);
    chk("R7 stalled add ignored", res_data, 16'hFEFF);

    // R4 / R3: remove then re-add restores value
    issue(2'd2, 16'h0100);
    issue(2'd3, 16'h0);
    chk("R4 remove to zero", res_data, 16'h0000);
    issue(2'd1, 16'hABCD);
    issue(2'd3, 16'h0);
    chk("R3 add after remove", res_data, 16'h5432);

    summary();
  end
endmodule